// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Configuration Port

This block gives software a narrow path into a bank of analog tuning bits for a group of transceiver ports. Instead of one register per field, a single shared control word carries an 8-bit internal bit address and one data bit. Each implemented port owns one strobe bit in the same word. Software sets up the address and data with the strobe low, then drives the strobe high and low again. The 0-to-1 transition of the strobe commits the data bit into the addressed location of that port's bank. Multi-bit fields are loaded least-significant bit first, one commit per bit, stepping the internal address upward.

The control word sits at byte offset 0x04 of a four-word register window on a simple 32-bit bus with byte enables. Byte-wide writes to the low byte leave the address byte untouched. Each port's whole bank drives a parallel output vector. A small set of shared tuning bits (PLL bandwidth and termination calibration enable) can be written through the strobe of any port and drives one common vector.

Top module: `cfgport_top`

## Requirements
- R1: After synchronous reset, the control word reads 0x00000000, every port configuration vector is zero and the shared vector is zero.
- R2: A read at offset 0x04 returns the last value written to the control word. The value appears on the read data bus at the clock edge that samples the read, and it holds until the next read.
- R3: A write to offset 0x04 updates only the bytes whose byte enable is set (enable bit b covers data bits 8b+7..8b). A write with only enable bit 0 set leaves the address byte (bits 15:8) unchanged.
- R4: Offsets 0x00, 0x08 and 0x0C read as zero. Writes to them change neither the control word nor any configuration output.
- R5: When a control write takes strobe bit 2n (port n) from 0 to 1, the data bit (bit 7) of the written word is stored at the internal address in bits 15:8 of the written word for port n. The result is visible at the clock edge that samples that write.
- R6: A control write that leaves a strobe bit high, even one with a new address or data, commits nothing. Configuration outputs change only on a strobe's 0-to-1 transition.
- R7: Port vector bit k holds internal address 0x20+k, for k = 0..11. The fields are: TX amplitude/slew tune 0x20-0x24, VBUS-valid threshold 0x25-0x26, pull-up select 0x27, OTG enable 0x28, VBUS detect enable 0x29, disconnect threshold 0x2A-0x2B. Port n occupies bits 12n+11..12n of the port output.
- R8: The shared vector bits 0, 1 and 2 hold internal addresses 0x03, 0x04 (PLL bandwidth, two bits) and 0x0C (calibration enable). A commit from any implemented port's strobe writes them.
- R9: Strobe bits of unimplemented ports (bit 6 with three ports) and all odd bits of the low byte commit nothing.
- R10: A commit to an internal address outside the map (anything other than 0x03, 0x04, 0x0C and 0x20-0x2B) changes no output.
- R11: A two-bit field written as two commits, least-significant bit first at consecutive addresses, reads back as the intended field value on the port vector.
- R12: Several strobes rising in one write each commit the same address and data bit into their own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Bus access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset within the window |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| port_cfg_o | output | NUM_PORTS*12 | Concatenated per-port configuration banks |
| shared_cfg_o | output | 3 | Shared configuration bits |

## Verification
The control word, every configuration vector and the read data register all change at the first rising edge that samples the access. Nothing is due later than one edge after a stimulus. The bench drives each access on a falling edge, holds it across exactly one rising edge, and compares outputs at the next falling edge, once each result has settled. The hold check rewrites the word with the strobe still high, and the ignored-strobe and out-of-map checks compare every output vector against the bench's model right after the offending write.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int BUS_W      = 32;
    localparam int BE_W       = BUS_W / 8;
    localparam int CTRL_OFS   = 4;
    localparam int IADDR_LSB  = 8;
    localparam int IADDR_W    = 8;
    localparam int DATA_POS   = 7;
    localparam int STROBE_STEP = 2;
    localparam int MAX_PORTS  = 3;
    localparam int IDX_W      = 4;

    // per-port bank; bit k of this struct is internal address 0x20+k
    typedef struct packed {
        logic [1:0] disc_thr;
        logic       vbus_det_en;
        logic       otg_en;
        logic       pullup_sel;
        logic [1:0] vbus_thr;
        logic [4:0] tx_tune;
    } port_cfg_t;

    // shared bank; bits 0,1 = 0x03,0x04 and bit 2 = 0x0C
    typedef struct packed {
        logic       cal_en;
        logic [1:0] pll_bw;
    } shared_cfg_t;

    localparam int PORT_BITS   = $bits(port_cfg_t);
    localparam int SHARED_BITS = $bits(shared_cfg_t);

    localparam logic [IADDR_W-1:0] PORT_BASE  = 8'h20;
    localparam logic [IADDR_W-1:0] PORT_END   = 8'h2C;
    localparam logic [IADDR_W-1:0] PLL_BW_LO  = 8'h03;
    localparam logic [IADDR_W-1:0] PLL_BW_HI  = 8'h04;
    localparam logic [IADDR_W-1:0] CAL_EN_ADR = 8'h0C;

    typedef struct packed {
        logic             port_hit;
        logic             shared_hit;
        logic [IDX_W-1:0] idx;
    } map_hit_t;

    typedef struct packed {
        logic             data;
        logic [IDX_W-1:0] idx;
    } commit_t;

    function automatic map_hit_t map_lookup(input logic [IADDR_W-1:0] a);
        map_hit_t h;
        h = '0;
        if (a >= PORT_BASE && a < PORT_END) begin
            h.port_hit = 1'b1;
            h.idx      = IDX_W'(a - PORT_BASE);
        end else begin
            unique case (a)
                PLL_BW_LO:  begin h.shared_hit = 1'b1; h.idx = 4'd0; end
                PLL_BW_HI:  begin h.shared_hit = 1'b1; h.idx = 4'd1; end
                CAL_EN_ADR: begin h.shared_hit = 1'b1; h.idx = 4'd2; end
                default:    h = '0;
            endcase
        end
        return h;
    endfunction

endpackage

// File: rtl/cfgport_ctrl_reg.sv
module cfgport_ctrl_reg
    import cfgport_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [BE_W-1:0]      bus_be_i,
    input  logic [BUS_W-1:0]     bus_wdata_i,
    output logic [BUS_W-1:0]     ctrl_o,
    output logic                 wr_ctrl_o,
    output logic [IADDR_W-1:0]   nxt_iaddr_o,
    output logic                 nxt_data_o,
    output logic [NUM_PORTS-1:0] nxt_strobe_o,
    output logic [NUM_PORTS-1:0] cur_strobe_o
);

    logic [BUS_W-1:0] ctrl_r;
    logic [BUS_W-1:0] ctrl_d;
    logic             wr_ctrl;

    assign wr_ctrl = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(CTRL_OFS));

    // byte-lane merge: only enabled lanes take new data
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign ctrl_d[b*8 +: 8] = (wr_ctrl && bus_be_i[b]) ? bus_wdata_i[b*8 +: 8]
                                                           : ctrl_r[b*8 +: 8];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctrl_r <= '0;
        else       ctrl_r <= ctrl_d;
    end

    for (genvar n = 0; n < NUM_PORTS; n++) begin : g_stb
        assign nxt_strobe_o[n] = ctrl_d[n*STROBE_STEP];
        assign cur_strobe_o[n] = ctrl_r[n*STROBE_STEP];
    end

    assign ctrl_o      = ctrl_r;
    assign wr_ctrl_o   = wr_ctrl;
    assign nxt_iaddr_o = ctrl_d[IADDR_LSB +: IADDR_W];
    assign nxt_data_o  = ctrl_d[DATA_POS];

endmodule

// File: rtl/cfgport_commit_decode.sv
module cfgport_commit_decode
    import cfgport_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  logic                 wr_ctrl_i,
    input  logic [IADDR_W-1:0]   iaddr_i,
    input  logic                 data_i,
    input  logic [NUM_PORTS-1:0] nxt_strobe_i,
    input  logic [NUM_PORTS-1:0] cur_strobe_i,
    output logic [NUM_PORTS-1:0] port_we_o,
    output logic                 shared_we_o,
    output commit_t              commit_o
);

    logic [NUM_PORTS-1:0] rise;
    map_hit_t             hit;

    assign hit = map_lookup(iaddr_i);

    for (genvar n = 0; n < NUM_PORTS; n++) begin : g_rise
        assign rise[n]      = wr_ctrl_i && nxt_strobe_i[n] && !cur_strobe_i[n];
        assign port_we_o[n] = rise[n] && hit.port_hit;
    end

    assign shared_we_o   = (|rise) && hit.shared_hit;
    assign commit_o.idx  = hit.idx;
    assign commit_o.data = data_i;

endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
    import cfgport_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  commit_t          commit_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (rst_i)
                q_o[i] <= 1'b0;
            else if (we_i && commit_i.idx == IDX_W'(i))
                q_o[i] <= commit_i.data;
        end
    end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic                           bus_sel_i,
    input  logic                           bus_wr_i,
    input  logic [ADDR_W-1:0]              bus_addr_i,
    input  logic [3:0]                     bus_be_i,
    input  logic [31:0]                    bus_wdata_i,
    output logic [31:0]                    bus_rdata_o,
    output logic [NUM_PORTS*PORT_BITS-1:0] port_cfg_o,
    output logic [SHARED_BITS-1:0]         shared_cfg_o
);

    logic [BUS_W-1:0]     ctrl_q;
    logic                 wr_ctrl;
    logic [IADDR_W-1:0]   nxt_iaddr;
    logic                 nxt_data;
    logic [NUM_PORTS-1:0] nxt_strobe;
    logic [NUM_PORTS-1:0] cur_strobe;
    logic [NUM_PORTS-1:0] port_we;
    logic                 shared_we;
    commit_t              commit;
    logic [BUS_W-1:0]     rdata_q;

    cfgport_ctrl_reg #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .bus_sel_i    (bus_sel_i),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .bus_be_i     (bus_be_i),
        .bus_wdata_i  (bus_wdata_i),
        .ctrl_o       (ctrl_q),
        .wr_ctrl_o    (wr_ctrl),
        .nxt_iaddr_o  (nxt_iaddr),
        .nxt_data_o   (nxt_data),
        .nxt_strobe_o (nxt_strobe),
        .cur_strobe_o (cur_strobe)
    );

    cfgport_commit_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .wr_ctrl_i    (wr_ctrl),
        .iaddr_i      (nxt_iaddr),
        .data_i       (nxt_data),
        .nxt_strobe_i (nxt_strobe),
        .cur_strobe_i (cur_strobe),
        .port_we_o    (port_we),
        .shared_we_o  (shared_we),
        .commit_o     (commit)
    );

    for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
        cfgport_bank #(.WIDTH(PORT_BITS)) u_bank (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .we_i     (port_we[n]),
            .commit_i (commit),
            .q_o      (port_cfg_o[n*PORT_BITS +: PORT_BITS])
        );
    end

    cfgport_bank #(.WIDTH(SHARED_BITS)) u_shared (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .we_i     (shared_we),
        .commit_i (commit),
        .q_o      (shared_cfg_o)
    );

    // registered read: only the control word is backed by storage
    always_ff @(posedge clk_i) begin
        if (rst_i)
            rdata_q <= '0;
        else if (bus_sel_i && !bus_wr_i)
            rdata_q <= (bus_addr_i == ADDR_W'(CTRL_OFS)) ? ctrl_q : '0;
    end

    assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker
    import cfgport_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 4
) (
    input logic                           clk_i,
    input logic                           rst_i,
    input logic                           bus_sel_i,
    input logic                           bus_wr_i,
    input logic [ADDR_W-1:0]              bus_addr_i,
    input logic [3:0]                     bus_be_i,
    input logic [31:0]                    bus_rdata_o,
    input logic [31:0]                    ctrl_q,
    input logic [NUM_PORTS*PORT_BITS-1:0] port_cfg_o,
    input logic [SHARED_BITS-1:0]         shared_cfg_o
);

    logic at_ctrl;
    assign at_ctrl = (bus_addr_i == ADDR_W'(CTRL_OFS));

    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (port_cfg_o == '0 && shared_cfg_o == '0 && ctrl_q == '0));

    assert_readback_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && !bus_wr_i && at_ctrl) |=> (bus_rdata_o == $past(ctrl_q)));

    assert_addr_byte_kept_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && bus_wr_i && at_ctrl && !bus_be_i[1])
            |=> (ctrl_q[15:8] == $past(ctrl_q[15:8])));

    assert_reserved_read_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && !bus_wr_i && !at_ctrl) |=> (bus_rdata_o == '0));

    assert_reserved_write_inert_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && bus_wr_i && !at_ctrl) |=> $stable(ctrl_q));

    assert_quiet_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bus_sel_i && bus_wr_i && at_ctrl)
            |=> ($stable(port_cfg_o) && $stable(shared_cfg_o)));

endmodule

bind cfgport_top cfgport_checker #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_sel_i    (bus_sel_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_be_i     (bus_be_i),
    .bus_rdata_o  (bus_rdata_o),
    .ctrl_q       (ctrl_q),
    .port_cfg_o   (port_cfg_o),
    .shared_cfg_o (shared_cfg_o)
);

// File: tb/test_cfgport_top.sv
`timescale 1ns/1ps
module test_cfgport_top;

    localparam int NP = 3;
    localparam int PB = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          wr  = 1'b0;
    logic [3:0]    addr = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP*PB-1:0] pcfg;
    logic [2:0]    scfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [PB-1:0] exp_p [NP];
    logic [2:0]    exp_s;

    always #4 clk = ~clk;

    cfgport_top #(.NUM_PORTS(NP), .ADDR_W(4)) i_cfgport_top (
        .clk_i(clk), .rst_i(rst), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .port_cfg_o(pcfg), .shared_cfg_o(scfg)
    );

    typedef struct packed {
        logic [2:0] mask;
        logic [7:0] iadr;
        logic       bitv;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{3'b001, 8'h20, 1'b1}, '{3'b010, 8'h24, 1'b1}, '{3'b100, 8'h2B, 1'b1},
        '{3'b001, 8'h27, 1'b1}, '{3'b010, 8'h25, 1'b1}, '{3'b001, 8'h20, 1'b0},
        '{3'b100, 8'h28, 1'b1}, '{3'b010, 8'h29, 1'b1}, '{3'b001, 8'h03, 1'b1},
        '{3'b100, 8'h0C, 1'b1}, '{3'b010, 8'h04, 1'b1}, '{3'b001, 8'h2A, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] e);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; be = e;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    // model of the map, taken from R7/R8 (mask bits beyond NP ignored, R9)
    function automatic void model(input logic [2:0] mask, input logic [7:0] a, input logic d);
        for (int n = 0; n < NP; n++) begin
            if (mask[n]) begin
                if (a >= 8'h20 && a < 8'h2C) exp_p[n][a - 8'h20] = d;
                else if (a == 8'h03) exp_s[0] = d;
                else if (a == 8'h04) exp_s[1] = d;
                else if (a == 8'h0C) exp_s[2] = d;
            end
        end
    endfunction

    function automatic logic [7:0] stb(input logic [3:0] mask);
        return {1'b0, mask[3], 1'b0, mask[2], 1'b0, mask[1], 1'b0, mask[0]};
    endfunction

    task automatic commit(input logic [3:0] mask, input logic [7:0] a, input logic d);
        bus_wr(4'h4, {16'h0, a, d, 7'h0}, 4'b0011);
        bus_wr(4'h4, {16'h0, a, (stb(mask) | {d, 7'h0})}, 4'b0001);
        bus_wr(4'h4, {16'h0, a, d, 7'h0}, 4'b0001);
    endtask

    task automatic check_all(input string req);
        check(req, 64'(pcfg), 64'({exp_p[2], exp_p[1], exp_p[0]}));
        check(req, 64'(scfg), 64'(exp_s));
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        for (int n = 0; n < NP; n++) exp_p[n] = '0;
        exp_s = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(4'h4, rv);
        check("R1 ctrl", 64'(rv), 64'h0);
        check_all("R1 outputs");

        // vector table: R5 commits, R7 port map, R8 shared map
        for (int i = 0; i < 12; i++) begin
            commit({1'b0, VEC[i].mask}, VEC[i].iadr, VEC[i].bitv);
            model(VEC[i].mask, VEC[i].iadr, VEC[i].bitv);
            check_all("R5 R7 R8 table");
        end

        // R2 readback of full word
        bus_wr(4'h4, 32'h1234_5600, 4'hF);
        bus_rd(4'h4, rv);
        check("R2 readback", 64'(rv), 64'h1234_5600);

        // R3 low-byte write keeps address byte
        bus_wr(4'h4, 32'hFFFF_FF80, 4'b0001);
        bus_rd(4'h4, rv);
        check("R3 byte lanes", 64'(rv), 64'h1234_5680);
        bus_wr(4'h4, 32'hAAAA_AAAA, 4'b0100);
        bus_rd(4'h4, rv);
        check("R3 lane 2", 64'(rv), 64'h12AA_5680);
        bus_wr(4'h4, 32'h0, 4'hF);

        // R4 reserved offsets
        bus_wr(4'h0, 32'hFFFF_FFFF, 4'hF);
        bus_wr(4'h8, 32'hFFFF_FFFF, 4'hF);
        bus_wr(4'hC, 32'hFFFF_FFFF, 4'hF);
        check_all("R4 reserved write");
        bus_rd(4'h4, rv);
        check("R4 ctrl kept", 64'(rv), 64'h0);
        bus_rd(4'h8, rv);
        check("R4 read zero", 64'(rv), 64'h0);

        // R6 held strobe
        bus_wr(4'h4, {16'h0, 8'h21, 8'h80}, 4'b0011);
        bus_wr(4'h4, {16'h0, 8'h21, 8'h84}, 4'b0001);
        model(3'b010, 8'h21, 1'b1);
        check_all("R6 first rise");
        bus_wr(4'h4, {16'h0, 8'h21, 8'h04}, 4'b0001);
        bus_wr(4'h4, {16'h0, 8'h26, 8'h84}, 4'b0011);
        check_all("R6 held high");
        bus_wr(4'h4, 32'h0, 4'hF);

        // R9 unimplemented and odd strobe bits
        bus_wr(4'h4, {16'h0, 8'h22, 8'h80}, 4'b0011);
        bus_wr(4'h4, {16'h0, 8'h22, 8'hEA}, 4'b0001);
        check_all("R9 ignored strobes");
        bus_wr(4'h4, 32'h0, 4'hF);

        // R10 out-of-map addresses
        commit(4'b0001, 8'h40, 1'b1);
        check_all("R10 addr 0x40");
        commit(4'b0111, 8'h05, 1'b1);
        check_all("R10 addr 0x05");

        // R12 simultaneous strobes
        commit(4'b0111, 8'h26, 1'b1);
        model(3'b111, 8'h26, 1'b1);
        check_all("R12 all ports");

        // R11 two-bit field LSB first: port 0 disconnect threshold = 2
        commit(4'b0001, 8'h2A, 1'b0);
        commit(4'b0001, 8'h2B, 1'b1);
        model(3'b001, 8'h2A, 1'b0);
        model(3'b001, 8'h2B, 1'b1);
        check("R11 field", 64'(pcfg[11:10]), 64'd2);
        check_all("R11 vectors");

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int n = 0; n < NP; n++) exp_p[n] = '0;
        exp_s = '0;
        check_all("R1 re-reset");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule